// File: doc/BRIEF.md
# Sliced Lookup-Table Sequential Trigger

This block watches a wide sampled data bus and decides when a capture trigger should fire. The bus is cut into equal slices. Each slice indexes its own small lookup memory, and every memory word holds one match bit for each trigger level. A level counts as satisfied for a sample only when every slice has that level's bit set at the entry its bits select. Because each slice's condition is a full lookup table rather than a comparator, one level can express exact values, don't-care bits, ranges or any other set of slice values. The level count is the memory word width.

A sequencer walks the levels in order after arming. It starts at level 0 and moves up one level for each sample that satisfies the current level. When the configured last level is satisfied, an optional delay counts a programmed number of further samples, or of samples flagged by an event input. The trigger output then rises and stays high until the block is armed again. The trigger is the qualifier that downstream capture logic uses to gate writes into its sample store. The tables are loaded through a simple write port that only works while the block is not armed.

Top module: `trig_seq_top`

## Requirements
- R1: Slice s of the sampled bus is `data_in[s*ADDR_W +: ADDR_W]`, and it addresses lookup memory s only. With the defaults, slice 0 is bits 3:0, slice 1 is bits 7:4 and slice 2 is bits 11:8.
- R2: Level j is satisfied by a sample only when bit j is set in the selected entry of every slice. If one slice disagrees, the level is not satisfied.
- R3: A rising `arm` puts the sequencer at level 0. Each valid sample that satisfies the current level advances it by one, and other samples leave it where it is. With `cfg_delay` = 0, `trig_out` rises on the second rising edge after the sample that satisfies level `cfg_last` is presented.
- R4: With `cfg_evt_mode` = 0 and `cfg_delay` = D > 0, the trigger rises on the second edge after the D-th valid sample that follows the final-level sample.
- R5: With `cfg_evt_mode` = 1, only valid samples presented with `evt_in` = 1 count toward the delay. The final-level sample itself never counts.
- R6: When `wr_en` = 1 and `arm` = 0 at a rising edge, `wr_data` is written into entry `wr_addr` of slice `wr_slice`. Bit j of `wr_data` is the level-j match bit. A write attempted while `arm` = 1 changes nothing.
- R7: Once high, `trig_out` stays high, including after `arm` falls. It is cleared by the first rising edge at which a new rising `arm` is seen.
- R8: A sample is valid only if `arm` was high at the edge before it was presented and is still high when it is presented. Samples presented while disarmed, or in the arming cycle itself, do not advance the sequencer.
- R9: While `rst` is high, `trig_out` is driven low at every edge and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | SLICES*ADDR_W | Sampled bus under observation |
| evt_in | input | 1 | Event flag that goes with the current sample; used by event-mode delay |
| arm | input | 1 | Level arm; a rising edge restarts recognition |
| wr_en | input | 1 | Table write strobe, honoured only while disarmed |
| wr_slice | input | SLICE_IW | Slice whose table is written |
| wr_addr | input | ADDR_W | Table entry address |
| wr_data | input | LEVELS | Match bits, one per level |
| cfg_last | input | LVL_IW | Index of the final level |
| cfg_delay | input | CNT_W | Delay after the final level, 0 for none |
| cfg_evt_mode | input | 1 | 0 counts samples, 1 counts flagged events |
| trig_out | output | 1 | Registered trigger word |

## Verification
A sample presented before edge N is read from the tables at edge N, and its level decision updates the sequencer at edge N+1. A resulting trigger is therefore visible just after edge N+1, and the bench reads it at the following falling edge, two steps after it drives the sample. An arm cleared by re-arming is visible at the falling edge right after the arm edge. The bench drives every input on falling edges and checks the trigger before driving the next sample, so each expected value is tied to the row that was presented two cycles earlier. Delay cases are checked both one cycle before and exactly at the due cycle.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEQ   = 2'd1,
    ST_DELAY = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/trig_slice_ram.sv
module trig_slice_ram #(
  parameter int AW = 4,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/trig_level_and.sv
module trig_level_and #(
  parameter int SLICES = 3,
  parameter int LEVELS = 4
) (
  input  logic [SLICES*LEVELS-1:0] slice_bits,
  output logic [LEVELS-1:0]        level_hit
);
  for (genvar j = 0; j < LEVELS; j++) begin : g_lvl
    logic [SLICES-1:0] col;
    for (genvar s = 0; s < SLICES; s++) begin : g_col
      assign col[s] = slice_bits[s*LEVELS + j];
    end
    assign level_hit[j] = &col;
  end
endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
  import trig_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int CNT_W  = 16,
  localparam int LVL_IW = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              smp_valid,
  input  logic              smp_evt,
  input  logic [LEVELS-1:0] level_hit,
  input  logic [LVL_IW-1:0] cfg_last,
  input  logic [CNT_W-1:0]  cfg_delay,
  input  logic              cfg_evt_mode,
  output logic              armed_q,
  output logic [LVL_IW-1:0] lvl_q,
  output logic              trig_q
);
  seq_state_t       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start;
  logic             qual;

  assign start = arm && !armed_q;
  assign qual  = smp_valid && (!cfg_evt_mode || smp_evt);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      st_q    <= ST_IDLE;
      lvl_q   <= '0;
      cnt_q   <= '0;
      trig_q  <= 1'b0;
    end else begin
      armed_q <= arm;
      if (start) begin
        st_q   <= ST_SEQ;
        lvl_q  <= '0;
        cnt_q  <= '0;
        trig_q <= 1'b0;
      end else if (smp_valid) begin
        unique case (st_q)
          ST_SEQ: begin
            if (level_hit[lvl_q]) begin
              if (lvl_q == cfg_last) begin
                if (cfg_delay == '0) begin
                  trig_q <= 1'b1;
                  st_q   <= ST_DONE;
                end else begin
                  cnt_q <= cfg_delay;
                  st_q  <= ST_DELAY;
                end
              end else begin
                lvl_q <= lvl_q + 1'b1;
              end
            end
          end
          ST_DELAY: begin
            if (qual) begin
              if (cnt_q == CNT_W'(1)) begin
                trig_q <= 1'b1;
                st_q   <= ST_DONE;
              end else begin
                cnt_q <= cnt_q - 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/trig_seq_top.sv
module trig_seq_top #(
  parameter int SLICES = 3,
  parameter int ADDR_W = 4,
  parameter int LEVELS = 4,
  parameter int CNT_W  = 16,
  localparam int DATA_W   = SLICES * ADDR_W,
  localparam int SLICE_IW = (SLICES > 1) ? $clog2(SLICES) : 1,
  localparam int LVL_IW   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   data_in,
  input  logic                evt_in,
  input  logic                arm,
  input  logic                wr_en,
  input  logic [SLICE_IW-1:0] wr_slice,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [LEVELS-1:0]   wr_data,
  input  logic [LVL_IW-1:0]   cfg_last,
  input  logic [CNT_W-1:0]    cfg_delay,
  input  logic                cfg_evt_mode,
  output logic                trig_out
);
  logic [SLICES*LEVELS-1:0] slice_bits;
  logic [LEVELS-1:0]        level_hit;
  logic                     armed_q;
  logic                     smp_valid;
  logic                     smp_evt;
  logic [LVL_IW-1:0]        lvl_q;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    logic we;
    assign we = wr_en && !arm && (wr_slice == SLICE_IW'(s));
    trig_slice_ram #(.AW(ADDR_W), .DW(LEVELS)) u_ram (
      .clk   (clk),
      .we    (we),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (data_in[s*ADDR_W +: ADDR_W]),
      .rdata (slice_bits[s*LEVELS +: LEVELS])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_valid <= 1'b0;
      smp_evt   <= 1'b0;
    end else begin
      smp_valid <= armed_q && arm;
      smp_evt   <= evt_in;
    end
  end

  trig_level_and #(.SLICES(SLICES), .LEVELS(LEVELS)) u_and (
    .slice_bits (slice_bits),
    .level_hit  (level_hit)
  );

  trig_sequencer #(.LEVELS(LEVELS), .CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .arm          (arm),
    .smp_valid    (smp_valid),
    .smp_evt      (smp_evt),
    .level_hit    (level_hit),
    .cfg_last     (cfg_last),
    .cfg_delay    (cfg_delay),
    .cfg_evt_mode (cfg_evt_mode),
    .armed_q      (armed_q),
    .lvl_q        (lvl_q),
    .trig_q       (trig_out)
  );
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int LVL_IW = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              arm,
  input logic              armed_q,
  input logic              smp_valid,
  input logic [LVL_IW-1:0] lvl_q,
  input logic              trig_out
);
  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (trig_out && !(arm && !armed_q)) |=> trig_out); // R7

  AST_REARM_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (arm && !armed_q) |=> !trig_out); // R7

  AST_RISE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_out) |-> $past(smp_valid)); // R8

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(armed_q) && !$past(rst)) |->
      (lvl_q == $past(lvl_q) || lvl_q == $past(lvl_q) + 1'b1)); // R3

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> !trig_out); // R9
endmodule

bind trig_seq_top trig_seq_chk #(.LVL_IW(LVL_IW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .arm       (arm),
  .armed_q   (armed_q),
  .smp_valid (smp_valid),
  .lvl_q     (lvl_q),
  .trig_out  (trig_out)
);

// File: tb/tb_trig_seq_top.sv
module tb_trig_seq_top;
  localparam int SLICES = 3;
  localparam int ADDR_W = 4;
  localparam int LEVELS = 4;
  localparam int CNT_W  = 16;
  localparam int NVEC   = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] data_in = '0;
  logic        evt_in = 1'b0;
  logic        arm = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_slice = '0;
  logic [3:0]  wr_addr = '0;
  logic [3:0]  wr_data = '0;
  logic [1:0]  cfg_last = '0;
  logic [15:0] cfg_delay = '0;
  logic        cfg_evt_mode = 1'b0;
  logic        trig_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // {expected trig at this row (result of row-2), data}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 12'h321}, {1'b0, 12'h124}, {1'b0, 12'h123}, {1'b0, 12'h457},
    {1'b0, 12'h789}, {1'b0, 12'h456}, {1'b0, 12'h123}, {1'b0, 12'h789},
    {1'b0, 12'h000}, {1'b1, 12'h000}, {1'b1, 12'h123}, {1'b1, 12'h000}
  };

  always #4 clk = ~clk;

  trig_seq_top #(.SLICES(SLICES), .ADDR_W(ADDR_W), .LEVELS(LEVELS), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .data_in(data_in), .evt_in(evt_in), .arm(arm),
    .wr_en(wr_en), .wr_slice(wr_slice), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_last(cfg_last), .cfg_delay(cfg_delay), .cfg_evt_mode(cfg_evt_mode),
    .trig_out(trig_out)
  );

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (trig_out !== exp) begin
      n_bad++;
      $display("FAIL %s: trig_out=%0b expected=%0b", req, trig_out, exp);
    end
  endtask

  task automatic step(input logic [11:0] d, input logic e);
    data_in = d;
    evt_in  = e;
    @(negedge clk);
  endtask

  task automatic tbl_wr(input int s, input int a, input logic [3:0] v);
    wr_en = 1'b1; wr_slice = 2'(s); wr_addr = 4'(a); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_arm();
    data_in = '0; evt_in = 1'b0;
    arm = 1'b0;
    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, got=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R9 reset");
    rst = 1'b0;
    @(negedge clk);
    check(1'b0, "R9 after reset");

    for (int s = 0; s < SLICES; s++)
      for (int a = 0; a < 16; a++) tbl_wr(s, a, 4'b0000);
    // level0 = 0x123, level1 = 0x456, level2 = 0x789 (R1, R2, R6)
    tbl_wr(0, 3, 4'b0001); tbl_wr(1, 2, 4'b0001); tbl_wr(2, 1, 4'b0001);
    tbl_wr(0, 6, 4'b0010); tbl_wr(1, 5, 4'b0010); tbl_wr(2, 4, 4'b0010);
    tbl_wr(0, 9, 4'b0100); tbl_wr(1, 8, 4'b0100); tbl_wr(2, 7, 4'b0100);

    // R8: samples while disarmed are ignored
    cfg_last = 2'd0; cfg_delay = '0; cfg_evt_mode = 1'b0;
    repeat (4) step(12'h123, 1'b0);
    check(1'b0, "R8 disarmed samples");

    // R1 R2 R3: three-level sequence from the table
    cfg_last = 2'd2;
    do_arm();
    for (int i = 0; i < NVEC; i++) begin
      check(VEC[i][12], $sformatf("R3 vector %0d", i));
      step(VEC[i][11:0], 1'b0);
    end

    // R7: hold after disarm, clear on re-arm
    arm = 1'b0;
    repeat (3) step(12'h000, 1'b0);
    check(1'b1, "R7 hold after disarm");
    do_arm();
    check(1'b0, "R7 clear on re-arm");

    // R4: sample-count delay of 3 after single-level match
    cfg_last = 2'd0; cfg_delay = 16'd3; cfg_evt_mode = 1'b0;
    step(12'h123, 1'b0);
    step(12'h000, 1'b0);
    step(12'h000, 1'b0);
    step(12'h000, 1'b0);
    check(1'b0, "R4 one cycle before delay expires");
    step(12'h000, 1'b0);
    check(1'b1, "R4 delay expired");

    // R5: event-count delay of 2
    cfg_delay = 16'd2; cfg_evt_mode = 1'b1;
    do_arm();
    step(12'h123, 1'b1);
    step(12'h000, 1'b0);
    step(12'h000, 1'b1);
    step(12'h000, 1'b0);
    check(1'b0, "R5 one event outstanding");
    step(12'h000, 1'b1);
    check(1'b0, "R5 one cycle before due");
    step(12'h000, 1'b0);
    check(1'b1, "R5 second event counted");

    // R6: writes while armed are ignored, while disarmed accepted
    cfg_delay = '0; cfg_evt_mode = 1'b0; cfg_last = 2'd0;
    do_arm();
    tbl_wr(0, 0, 4'b0001); tbl_wr(1, 0, 4'b0001); tbl_wr(2, 0, 4'b0001);
    repeat (4) step(12'h000, 1'b0);
    check(1'b0, "R6 write while armed ignored");
    arm = 1'b0;
    step(12'h000, 1'b0);
    tbl_wr(0, 0, 4'b0001); tbl_wr(1, 0, 4'b0001); tbl_wr(2, 0, 4'b0001);
    do_arm();
    step(12'h000, 1'b0);
    check(1'b0, "R6 result not yet due");
    step(12'h000, 1'b0);
    check(1'b1, "R6 write while disarmed accepted");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule